// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, for each received frame, whether its destination address should be taken in. The receiver presents the six destination bytes with a one-cycle strobe. One clock later the block returns a verdict. An individual (unicast) address is accepted only when it equals the programmed station address. A group address is reduced to a 6-bit index through a reflected CRC-32, and that index selects one bit of a 64-bit hash filter. A promiscuous input accepts everything.

Software loads the station address and the hash filter through two byte ports: a configuration port and a data port whose pointer advances by itself. A configuration write may raise a change request. That request stays pending until the receiver is between frames. While it is pending, data writes are dropped, so lookups keep using the old contents. Once the request reads back as clear, software writes the bytes in order and then writes zero to the configuration port.

Top module: `rx_addr_filter`

## Requirements
- R1: After synchronous reset, `cfg_rdata` is 0 and `acc_valid` and `acc` are 0. The station address and hash filter are all zeros, so the all-zero unicast address is accepted and the broadcast address is rejected.
- R2: `acc_valid` is high exactly in the cycle after a cycle with `da_valid` high. `acc` is 0 whenever `acc_valid` is 0.
- R3: When bit 0 of `da` (the group bit of the first byte) is 0, the frame is accepted only if all six bytes equal the station address. `da[7:0]` is the first byte on the wire. Station byte i is the i-th byte written after the pointer was reset.
- R4: When bit 0 of `da` is 1, the index is bits 31:26 of a CRC-32 computed as follows: polynomial 0xEDB88320 in reflected form, start value all ones, no final inversion, bytes 0..5 in order, each byte least significant bit first. The frame is accepted only if bit index[2:0] of filter byte index[5:3] is 1. Filter byte j is the j-th byte written.
- R5: With `promisc` high, every strobed address is accepted, whatever the filter and station contents.
- R6: A configuration byte is laid out as follows: bit 7 is the change request; bits 1:0 select the target (01 station, 10 hash filter, 00 and 11 none). `cfg_rdata` returns {request, 5'b0, target}. A request that is set stays set while `rx_busy` is high. It clears at the first clock edge that sees `rx_busy` low.
- R7: A data write is ignored while the request is pending, when the target is 00 or 11, or in a cycle that also carries a configuration write.
- R8: Every configuration write resets the byte pointer to 0. Each accepted data write stores into the selected target at the pointer and advances it. Writes beyond byte 5 of the station address or byte 7 of the filter are ignored.
- R9: Writing all eight filter bytes as 0xFF accepts every group address. Writing them as 0x00 rejects every group address.
- R10: A lookup strobed in the same cycle as a data write is judged against the contents before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte: request in bit 7, target in bits 1:0 |
| cfg_rdata | output | 8 | Request status and current target |
| data_wr | input | 1 | Address data byte write strobe |
| data_wdata | input | 8 | Address data byte |
| rx_busy | input | 1 | Receiver is inside a frame |
| promisc | input | 1 | Accept all frames |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first wire byte in bits 7:0 |
| acc_valid | output | 1 | Verdict valid, one cycle after the strobe |
| acc | output | 1 | Frame accepted |

## Verification
A filter lookup and a filter byte write can land on the same clock edge. The bench provokes this by loading seven filter bytes as 0xFF over a zeroed filter. It then issues the eighth write together with a strobe for a group address whose index falls in that last byte. The verdict must be a rejection, because the old byte was zero, and a repeat lookup one cycle later must accept. A second overlap comes from a change request raised while `rx_busy` is high. Data written during that window must not reach the contents that later lookups see.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int          DEF_ADDR_BYTES = 6;
    localparam int          DEF_FILT_BYTES = 8;
    localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED       = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        TGT_NONE    = 2'b00,
        TGT_STATION = 2'b01,
        TGT_HASH    = 2'b10,
        TGT_RSVD    = 2'b11
    } tgt_e;

    typedef struct packed {
        logic req;
        tgt_e tgt;
    } cfg_t;

    function automatic logic [7:0] cfg_pack(cfg_t c);
        return {c.req, 5'b0, c.tgt};
    endfunction

endpackage

// File: rtl/rxaf_hash.sv
module rxaf_hash
    import rxaf_pkg::*;
#(
    parameter int ADDR_BYTES = DEF_ADDR_BYTES,
    parameter int IDX_W      = 6
) (
    input  logic [ADDR_BYTES*8-1:0] da,
    output logic [IDX_W-1:0]        idx
);
    localparam int NBITS = ADDR_BYTES * 8;

    logic [31:0] crc;

    // Reflected CRC, bit-serial order unrolled: bit 0 of byte 0 enters first.
    always_comb begin
        crc = CRC_SEED;
        for (int i = 0; i < NBITS; i++) begin
            if (crc[0] ^ da[i])
                crc = (crc >> 1) ^ CRC_POLY_REFL;
            else
                crc = crc >> 1;
        end
    end

    assign idx = crc[31 -: IDX_W];

endmodule

// File: rtl/rxaf_prog.sv
module rxaf_prog
    import rxaf_pkg::*;
#(
    parameter int ADDR_BYTES = DEF_ADDR_BYTES,
    parameter int FILT_BYTES = DEF_FILT_BYTES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [7:0]              cfg_wdata,
    output logic [7:0]              cfg_rdata,
    input  logic                    data_wr,
    input  logic [7:0]              data_wdata,
    input  logic                    rx_busy,
    output logic [ADDR_BYTES*8-1:0] station,
    output logic [FILT_BYTES*8-1:0] filt
);
    localparam int MAXB = (ADDR_BYTES > FILT_BYTES) ? ADDR_BYTES : FILT_BYTES;
    localparam int PW   = $clog2(MAXB + 1);
    localparam logic [PW-1:0] STA_END = PW'(ADDR_BYTES);
    localparam logic [PW-1:0] FLT_END = PW'(FILT_BYTES);

    cfg_t          cfg_q;
    logic [PW-1:0] ptr_q;
    logic          room;
    logic          wr_ok;

    always_comb begin
        unique case (cfg_q.tgt)
            TGT_STATION: room = (ptr_q < STA_END);
            TGT_HASH:    room = (ptr_q < FLT_END);
            default:     room = 1'b0;
        endcase
    end

    assign wr_ok     = data_wr && !cfg_wr && !cfg_q.req && room;
    assign cfg_rdata = cfg_pack(cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{req: 1'b0, tgt: TGT_NONE};
            ptr_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.req <= cfg_wdata[7];
            cfg_q.tgt <= tgt_e'(cfg_wdata[1:0]);
            ptr_q     <= '0;
        end else begin
            if (cfg_q.req && !rx_busy)
                cfg_q.req <= 1'b0;
            if (wr_ok)
                ptr_q <= ptr_q + PW'(1);
        end
    end

    for (genvar s = 0; s < ADDR_BYTES; s++) begin : g_sta
        always_ff @(posedge clk) begin
            if (rst)
                station[s*8 +: 8] <= '0;
            else if (wr_ok && cfg_q.tgt == TGT_STATION && ptr_q == PW'(s))
                station[s*8 +: 8] <= data_wdata;
        end
    end

    for (genvar f = 0; f < FILT_BYTES; f++) begin : g_flt
        always_ff @(posedge clk) begin
            if (rst)
                filt[f*8 +: 8] <= '0;
            else if (wr_ok && cfg_q.tgt == TGT_HASH && ptr_q == PW'(f))
                filt[f*8 +: 8] <= data_wdata;
        end
    end

endmodule

// File: rtl/rxaf_match.sv
module rxaf_match
    import rxaf_pkg::*;
#(
    parameter int ADDR_BYTES = DEF_ADDR_BYTES,
    parameter int FILT_BYTES = DEF_FILT_BYTES,
    parameter int IDX_W      = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    da_valid,
    input  logic [ADDR_BYTES*8-1:0] da,
    input  logic [ADDR_BYTES*8-1:0] station,
    input  logic [FILT_BYTES*8-1:0] filt,
    input  logic [IDX_W-1:0]        idx,
    input  logic                    promisc,
    output logic                    acc_valid,
    output logic                    acc
);
    logic group_addr;
    logic take;

    assign group_addr = da[0];

    always_comb begin
        if (promisc)
            take = 1'b1;
        else if (group_addr)
            take = filt[idx];
        else
            take = (da == station);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid <= 1'b0;
            acc       <= 1'b0;
        end else begin
            acc_valid <= da_valid;
            acc       <= da_valid && take;
        end
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int ADDR_BYTES = DEF_ADDR_BYTES,
    parameter int FILT_BYTES = DEF_FILT_BYTES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [7:0]              cfg_wdata,
    output logic [7:0]              cfg_rdata,
    input  logic                    data_wr,
    input  logic [7:0]              data_wdata,
    input  logic                    rx_busy,
    input  logic                    promisc,
    input  logic                    da_valid,
    input  logic [ADDR_BYTES*8-1:0] da,
    output logic                    acc_valid,
    output logic                    acc
);
    localparam int IDX_W = $clog2(FILT_BYTES * 8);

    logic [ADDR_BYTES*8-1:0] station;
    logic [FILT_BYTES*8-1:0] filt;
    logic [IDX_W-1:0]        idx;

    rxaf_prog #(.ADDR_BYTES(ADDR_BYTES), .FILT_BYTES(FILT_BYTES)) u_prog (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .data_wr(data_wr), .data_wdata(data_wdata), .rx_busy(rx_busy),
        .station(station), .filt(filt)
    );

    rxaf_hash #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_hash (
        .da(da), .idx(idx)
    );

    rxaf_match #(.ADDR_BYTES(ADDR_BYTES), .FILT_BYTES(FILT_BYTES), .IDX_W(IDX_W)) u_match (
        .clk(clk), .rst(rst), .da_valid(da_valid), .da(da),
        .station(station), .filt(filt), .idx(idx), .promisc(promisc),
        .acc_valid(acc_valid), .acc(acc)
    );

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr,
    input logic       wreq,
    input logic [1:0] wtgt,
    input logic [7:0] cfg_rdata,
    input logic       rx_busy,
    input logic       promisc,
    input logic       da_valid,
    input logic       acc_valid,
    input logic       acc
);
    p_strobe_to_valid_r2: assert property (@(posedge clk) disable iff (rst)
        da_valid |=> acc_valid);

    p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !da_valid |=> !acc_valid);

    p_no_accept_without_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !acc);

    p_promisc_accepts_r5: assert property (@(posedge clk) disable iff (rst)
        (da_valid && promisc) |=> acc);

    p_req_holds_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[7] && rx_busy && !cfg_wr) |=> cfg_rdata[7]);

    p_req_clears_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[7] && !rx_busy && !cfg_wr) |=> !cfg_rdata[7]);

    p_cfg_reflects_write_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_rdata[7] == $past(wreq)) && (cfg_rdata[1:0] == $past(wtgt)));

    p_cfg_pad_zero_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[6:2] == 5'b0);

endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .wreq(cfg_wdata[7]),
    .wtgt(cfg_wdata[1:0]), .cfg_rdata(cfg_rdata), .rx_busy(rx_busy),
    .promisc(promisc), .da_valid(da_valid), .acc_valid(acc_valid), .acc(acc)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        data_wr = 1'b0;
    logic [7:0]  data_wdata = '0;
    logic        rx_busy = 1'b0;
    logic        promisc = 1'b0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        acc_valid;
    logic        acc;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_sta [6];
    logic [7:0] m_flt [8];

    always #2 clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .data_wr(data_wr), .data_wdata(data_wdata),
        .rx_busy(rx_busy), .promisc(promisc), .da_valid(da_valid), .da(da),
        .acc_valid(acc_valid), .acc(acc)
    );

    typedef struct packed {
        logic [47:0] addr;
        logic        pr;
    } vec_t;

    localparam logic [47:0] A_STA = 48'h554433221102;
    localparam logic [47:0] A_MCA = 48'h0100005e0001;
    localparam logic [47:0] A_MCB = 48'h010000003333;
    localparam logic [47:0] A_MCC = 48'hfaff7f5e0001;
    localparam logic [47:0] A_BC  = 48'hffffffffffff;

    localparam vec_t VECS [10] = '{
        '{A_STA, 1'b0},
        '{48'h564433221102, 1'b0},
        '{48'h554433221104, 1'b0},
        '{A_MCA, 1'b0},
        '{A_MCB, 1'b0},
        '{A_MCC, 1'b0},
        '{A_BC, 1'b0},
        '{48'h0a0b0c0d0e10, 1'b1},
        '{A_MCC, 1'b1},
        '{48'h000000000000, 1'b0}
    };

    function automatic logic [5:0] ref_idx(logic [47:0] a);
        logic [31:0] r = 32'hFFFFFFFF;
        for (int b = 0; b < 6; b++) begin
            logic [7:0] v = a[b*8 +: 8];
            for (int k = 0; k < 8; k++) begin
                if (r[0] ^ v[k]) r = (r >> 1) ^ 32'hEDB88320;
                else             r = r >> 1;
            end
        end
        return r[31:26];
    endfunction

    function automatic logic ref_acc(logic [47:0] a, logic pr);
        logic [5:0] ix;
        logic       same;
        if (pr) return 1'b1;
        if (a[0]) begin
            ix = ref_idx(a);
            return m_flt[ix[5:3]][ix[2:0]];
        end
        same = 1'b1;
        for (int b = 0; b < 6; b++)
            if (a[b*8 +: 8] != m_sta[b]) same = 1'b0;
        return same;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        data_wr = 1'b1; data_wdata = v;
        tick();
        data_wr = 1'b0;
    endtask

    task automatic lookup(input logic [47:0] a, input logic pr, input string tag);
        logic e;
        e = ref_acc(a, pr);
        da = a; promisc = pr; da_valid = 1'b1;
        tick();
        da_valid = 1'b0; promisc = 1'b0;
        chk({tag, " valid"}, 64'(acc_valid), 64'd1);
        chk({tag, " accept"}, 64'(acc), 64'(e));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] x;
        logic        found;
        logic [5:0]  ix;
        for (int i = 0; i < 6; i++) m_sta[i] = 8'h00;
        for (int i = 0; i < 8; i++) m_flt[i] = 8'h00;

        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        chk("R1 cfg_rdata", 64'(cfg_rdata), 64'h0);
        chk("R1 acc_valid", 64'(acc_valid), 64'd0);
        chk("R1 acc", 64'(acc), 64'd0);
        lookup(48'h0, 1'b0, "R1 zero unicast");
        lookup(A_BC, 1'b0, "R1 broadcast");

        // R6/R7: request held while busy, data dropped meanwhile
        rx_busy = 1'b1;
        wr_cfg(8'h81);
        chk("R6 pending", 64'(cfg_rdata), 64'h81);
        wr_data(8'hAA);
        chk("R6 still pending", 64'(cfg_rdata), 64'h81);
        rx_busy = 1'b0;
        tick();
        chk("R6 cleared", 64'(cfg_rdata), 64'h01);

        // R3/R8: six station bytes then one beyond the end
        for (int b = 0; b < 6; b++) begin
            wr_data(A_STA[b*8 +: 8]);
            m_sta[b] = A_STA[b*8 +: 8];
        end
        wr_data(8'h99);
        wr_cfg(8'h00);
        lookup(A_STA, 1'b0, "R7 R8 station intact");

        // R4: hash filter holding A and B
        ix = ref_idx(A_MCA); m_flt[ix[5:3]][ix[2:0]] = 1'b1;
        ix = ref_idx(A_MCB); m_flt[ix[5:3]][ix[2:0]] = 1'b1;
        wr_cfg(8'h82);
        tick();
        chk("R6 hash target", 64'(cfg_rdata), 64'h02);
        for (int b = 0; b < 8; b++) wr_data(m_flt[b]);
        wr_cfg(8'h00);

        // R3 R4 R5: vector table
        for (int v = 0; v < 10; v++) begin
            if (VECS[v].pr)          lookup(VECS[v].addr, 1'b1, "R5 vec");
            else if (VECS[v].addr[0]) lookup(VECS[v].addr, 1'b0, "R4 vec");
            else                     lookup(VECS[v].addr, 1'b0, "R3 vec");
        end
        tick();
        chk("R2 valid drops", 64'(acc_valid), 64'd0);

        // R9: all-zero filter
        wr_cfg(8'h02);
        for (int b = 0; b < 8; b++) begin wr_data(8'h00); m_flt[b] = 8'h00; end
        lookup(A_BC, 1'b0, "R9 zero filter bc");
        lookup(A_MCA, 1'b0, "R9 zero filter A");

        // R10: lookup in the same cycle as the last filter byte write
        found = 1'b0; x = '0;
        for (int i = 0; i < 256; i++) begin
            logic [47:0] c;
            logic [5:0]  ci;
            c  = {8'(i), 40'h00005e0001};
            ci = ref_idx(c);
            if (!found && ci[5:3] == 3'd7) begin x = c; found = 1'b1; end
        end
        chk("R10 candidate found", 64'(found), 64'd1);
        wr_cfg(8'h02);
        for (int b = 0; b < 7; b++) begin wr_data(8'hFF); m_flt[b] = 8'hFF; end
        data_wr = 1'b1; data_wdata = 8'hFF;
        da = x; da_valid = 1'b1;
        tick();
        data_wr = 1'b0; da_valid = 1'b0;
        chk("R10 same-cycle old contents", 64'(acc), 64'd0);
        m_flt[7] = 8'hFF;
        lookup(x, 1'b0, "R10 after write");
        lookup(A_BC, 1'b0, "R9 ones filter bc");
        lookup(A_MCC, 1'b0, "R9 ones filter C");

        // R8: pointer restarts at byte 0 on a new configuration write
        wr_cfg(8'h01);
        wr_data(8'h06); m_sta[0] = 8'h06;
        wr_cfg(8'h00);
        lookup(48'h554433221106, 1'b0, "R8 rewritten byte0");
        lookup(A_STA, 1'b0, "R8 old station");

        // R7: reserved target and same-cycle config write ignore data
        wr_cfg(8'h03);
        wr_data(8'h08);
        cfg_wr = 1'b1; cfg_wdata = 8'h01; data_wr = 1'b1; data_wdata = 8'h0A;
        tick();
        cfg_wr = 1'b0; data_wr = 1'b0;
        wr_cfg(8'h00);
        lookup(48'h554433221106, 1'b0, "R7 ignored writes");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule